// File: doc/BRIEF.md
# Multi-Chain Scan Wrapper

This block wraps a small combinational core with a register of state flip-flops, and every one of those flip-flops is a multiplexed-D scan cell. One test-control pin, `tc`, selects the mode for all cells at once. When `tc` is high, each cell captures the next-state value that the core computes. When `tc` is low, the cells form several independent shift registers, and each shift register moves one bit per clock.

The state register is cut into `NCH` chains, and the chains need not all have the same length. Each chain takes its serial input from one of the functional input pins and sends its serial output out on one of the functional output pins, so the block needs no dedicated scan pins. A small multiplexer on each shared output pin, steered by `tc`, chooses between the core's output and the last cell of the chain. A tester loads a state by shifting, applies one capture clock with `tc` high, and then shifts the response back out through the same pins.

All flip-flops run on the single `clk` input. No clock reaches a data path. An active-low reset clears every cell at once and is released through a two-stage synchronizer.

Top module: `scan_wrapper`

## Requirements
- R1: After reset, every state cell holds 0. With `tc` low and `pi` all zero, every `po` pin reads 0.
- R2: With `tc` = 1, every cell loads the core's next-state value at the rising clock edge.
- R3: With `tc` = 0, every chain moves its contents one cell toward its tail on each rising edge. The head cell of chain c loads `pi[c]`.
- R4: With `tc` = 0, output pin `po[c]` (c < `NCH`) shows the tail cell of chain c. Output pins with index `NCH` or higher always carry the core output.
- R5: With `tc` = 1, every `po` pin carries the core output. The `pi` pins feed the core in both modes.
- R6: Chain c holds `NFF/NCH` cells, plus one more when c < `NFF%NCH`. The chains take consecutive cell indices, chain 0 starting at cell 0. Within a chain the lowest index is the head and the highest is the tail. With the defaults, the chains span cells 0-3, 4-6 and 7-9.
- R7: Next state of cell i = state[(i-1) mod NFF] XOR pi[i mod NPI].
- R8: Core output j = state[j] XOR state[NFF-1-j] XOR pi[j].
- R9: Driving `rst_n` low clears all cells and the outputs derived from them without waiting for a clock edge. After `rst_n` rises, the first two rising edges still clear the cells, and the third edge is the first one that changes the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for every cell |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tc | input | 1 | Test control: 1 = functional capture, 0 = shift |
| pi | input | NPI | Functional inputs; bits 0..NCH-1 also act as chain serial inputs |
| po | output | NPO | Functional outputs; bits 0..NCH-1 also act as chain serial outputs |

## Verification
The outputs are combinational functions of the state and `pi`. The bench therefore drives new inputs on the falling edge and compares `po` 2 ns later, still inside the same cycle. A capture or shift takes effect at the next rising edge, and its result becomes visible on `po` in the compare of the following cycle. The reference model moves its own state only at rising edges. After reset release, the model holds its state at zero for two edges before it lets the state change. Reset assertion is checked within the same cycle, with no clock edge between the drop of `rst_n` and the compare.

// File: rtl/scan_wrapper_pkg.sv
package scan_wrapper_pkg;

  // number of cells in chain c when nff cells are split over nch chains
  function automatic int chain_len(input int nff, input int nch, input int c);
    return (nff / nch) + ((c < (nff % nch)) ? 1 : 0);
  endfunction

  // index of the head cell of chain c
  function automatic int chain_head(input int nff, input int nch, input int c);
    int acc;
    acc = 0;
    for (int k = 0; k < c; k++) acc += chain_len(nff, nch, k);
    return acc;
  endfunction

  // index of the tail cell of chain c
  function automatic int chain_tail(input int nff, input int nch, input int c);
    return chain_head(nff, nch, c) + chain_len(nff, nch, c) - 1;
  endfunction

endpackage

// File: rtl/scan_wrapper_rstsync.sv
module scan_wrapper_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stg1_q, stg2_q;
  logic stg1_d, stg2_d;

  always_comb begin
    stg1_d = 1'b1;
    stg2_d = stg1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= stg1_d;
      stg2_q <= stg2_d;
    end
  end

  assign rst_q_n = stg2_q;
endmodule

// File: rtl/scan_wrapper_cell.sv
module scan_wrapper_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic tc,
  input  logic d,
  input  logic si,
  output logic q
);
  logic q_nxt;

  // tc high: functional data; tc low: serial data
  always_comb begin
    q_nxt = tc ? d : si;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/scan_wrapper_core.sv
module scan_wrapper_core #(
  parameter int NFF = 10,
  parameter int NPI = 4,
  parameter int NPO = 4
) (
  input  logic [NFF-1:0] st,
  input  logic [NPI-1:0] pi,
  output logic [NFF-1:0] ns,
  output logic [NPO-1:0] po_core
);
  for (genvar i = 0; i < NFF; i++) begin : g_ns
    assign ns[i] = st[(i + NFF - 1) % NFF] ^ pi[i % NPI];
  end

  for (genvar j = 0; j < NPO; j++) begin : g_po
    assign po_core[j] = st[j] ^ st[NFF-1-j] ^ pi[j];
  end
endmodule

// File: rtl/scan_wrapper.sv
module scan_wrapper #(
  parameter int NFF = 10,
  parameter int NCH = 3,
  parameter int NPI = 4,
  parameter int NPO = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tc,
  input  logic [NPI-1:0] pi,
  output logic [NPO-1:0] po
);
  import scan_wrapper_pkg::*;

  logic           rst_q_n;
  logic [NFF-1:0] q;
  logic [NFF-1:0] ns;
  logic [NFF-1:0] sin;
  logic [NPO-1:0] po_core;

  scan_wrapper_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  scan_wrapper_core #(.NFF(NFF), .NPI(NPI), .NPO(NPO)) u_core (
    .st      (q),
    .pi      (pi),
    .ns      (ns),
    .po_core (po_core)
  );

  // chain stitching: the head takes the shared pin, the others take their upstream cell
  for (genvar c = 0; c < NCH; c++) begin : g_chain
    localparam int HEAD = chain_head(NFF, NCH, c);
    localparam int LEN  = chain_len(NFF, NCH, c);
    for (genvar k = 0; k < LEN; k++) begin : g_link
      if (k == 0) begin : g_head
        assign sin[HEAD] = pi[c];
      end else begin : g_body
        assign sin[HEAD+k] = q[HEAD+k-1];
      end
    end
  end

  for (genvar i = 0; i < NFF; i++) begin : g_cell
    scan_wrapper_cell u_cell (
      .clk   (clk),
      .rst_n (rst_q_n),
      .tc    (tc),
      .d     (ns[i]),
      .si    (sin[i]),
      .q     (q[i])
    );
  end

  // output pin sharing
  for (genvar j = 0; j < NPO; j++) begin : g_out
    if (j < NCH) begin : g_shared
      localparam int TAIL = chain_tail(NFF, NCH, j);
      assign po[j] = tc ? po_core[j] : q[TAIL];
    end else begin : g_plain
      assign po[j] = po_core[j];
    end
  end
endmodule

// File: rtl/scan_wrapper_chk.sv
module scan_wrapper_chk #(
  parameter int NFF = 10,
  parameter int NCH = 3,
  parameter int NPI = 4,
  parameter int NPO = 4
) (
  input logic           clk,
  input logic           rst_q_n,
  input logic           tc,
  input logic [NPI-1:0] pi,
  input logic [NPO-1:0] po,
  input logic [NFF-1:0] q
);
  import scan_wrapper_pkg::*;

  // R1: cells are zero when the synchronized reset lets go
  a_r1_reset_clear: assert property (@(posedge clk) $rose(rst_q_n) |-> (q == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    localparam int HEAD = chain_head(NFF, NCH, c);
    localparam int TAIL = chain_tail(NFF, NCH, c);

    // R3, R6: head cell takes its shared input pin in shift mode
    a_r3_head_entry: assert property (@(posedge clk) disable iff (!rst_q_n)
      !tc |=> q[HEAD] == $past(pi[c]));

    for (genvar k = HEAD + 1; k <= TAIL; k++) begin : g_k
      // R3: bits advance one cell per clock toward the tail
      a_r3_advance: assert property (@(posedge clk) disable iff (!rst_q_n)
        !tc |=> q[k] == $past(q[k-1]));
    end

    // R4: shared output shows the chain tail in shift mode
    a_r4_tail_out: assert property (@(posedge clk) disable iff (!rst_q_n)
      !tc |-> po[c] == q[TAIL]);
  end

  for (genvar i = 0; i < NFF; i++) begin : g_i
    // R2, R7: capture loads the next-state function
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_q_n)
      tc |=> q[i] == ($past(q[(i + NFF - 1) % NFF]) ^ $past(pi[i % NPI])));
  end

  for (genvar j = 0; j < NPO; j++) begin : g_j
    // R5, R8: functional outputs
    a_r5_func_out: assert property (@(posedge clk) disable iff (!rst_q_n)
      (tc || (j >= NCH)) |-> po[j] == (q[j] ^ q[NFF-1-j] ^ pi[j]));
  end
endmodule

bind scan_wrapper scan_wrapper_chk #(.NFF(NFF), .NCH(NCH), .NPI(NPI), .NPO(NPO)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .tc      (tc),
  .pi      (pi),
  .po      (po),
  .q       (q)
);

// File: tb/tb_scan_wrapper.sv
`timescale 1ns/1ps
module tb_scan_wrapper;
  localparam int NFF = 10;
  localparam int NCH = 3;
  localparam int NPI = 4;
  localparam int NPO = 4;

  logic           clk;
  logic           rst_n;
  logic           tc;
  logic [NPI-1:0] pi;
  logic [NPO-1:0] po;

  int  n_vec, n_bad;
  bit  done;
  bit  st [NFF];
  int  rcnt;

  scan_wrapper #(.NFF(NFF), .NCH(NCH), .NPI(NPI), .NPO(NPO)) dut (
    .clk(clk), .rst_n(rst_n), .tc(tc), .pi(pi), .po(po)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // R6: chain partition computed from the requirement text
  function automatic int len_of(int c);
    return NFF / NCH + ((c < NFF % NCH) ? 1 : 0);
  endfunction
  function automatic int head_of(int c);
    int h = 0;
    for (int k = 0; k < c; k++) h += len_of(k);
    return h;
  endfunction

  function automatic logic [NPO-1:0] expect_po(bit t, logic [NPI-1:0] p);
    logic [NPO-1:0] e;
    for (int j = 0; j < NPO; j++) begin
      e[j] = st[j] ^ st[NFF-1-j] ^ p[j];                 // R8
      if (!t && j < NCH) e[j] = st[head_of(j) + len_of(j) - 1]; // R4
    end
    return e;
  endfunction

  task automatic model_edge(bit r, bit t, logic [NPI-1:0] p);
    bit nx [NFF];
    if (!r) begin
      rcnt = 0;
      foreach (st[i]) st[i] = 1'b0;
    end else if (rcnt < 2) begin       // R9: two edges still in reset
      rcnt++;
      foreach (st[i]) st[i] = 1'b0;
    end else if (t) begin              // R2, R7
      for (int i = 0; i < NFF; i++) nx[i] = st[(i + NFF - 1) % NFF] ^ p[i % NPI];
      st = nx;
    end else begin                     // R3
      for (int c = 0; c < NCH; c++) begin
        for (int k = head_of(c) + len_of(c) - 1; k > head_of(c); k--) st[k] = st[k-1];
        st[head_of(c)] = p[c];
      end
    end
  endtask

  task automatic step(bit r, bit t, logic [NPI-1:0] p, string tag);
    logic [NPO-1:0] e;
    @(negedge clk);
    rst_n = r; tc = t; pi = p;
    if (!r) begin
      rcnt = 0;
      foreach (st[i]) st[i] = 1'b0;
    end
    #2;
    e = expect_po(t, p);
    n_vec++;
    if (po !== e) begin
      n_bad++;
      $display("FAIL %s tc=%0b pi=%b po=%b expected=%b", tag, t, p, po, e);
    end
    @(posedge clk);
    model_edge(r, t, p);
  endtask

  initial begin
    logic [15:0] lf;
    n_vec = 0; n_bad = 0; done = 0; rcnt = 0;
    foreach (st[i]) st[i] = 1'b0;
    rst_n = 1'b0; tc = 1'b0; pi = '0;

    // R1: reset state
    repeat (3) step(1'b0, 1'b0, 4'b0000, "R1 reset");
    step(1'b0, 1'b1, 4'b0000, "R1 reset functional view");

    // R9: release latency, inputs active during the two held edges
    step(1'b1, 1'b1, 4'b1111, "R9 release edge1");
    step(1'b1, 1'b1, 4'b1010, "R9 release edge2");
    step(1'b1, 1'b1, 4'b0110, "R9 first live edge");

    // R2, R5, R7, R8: functional capture under several patterns
    step(1'b1, 1'b1, 4'b0001, "R2 R7 capture");
    step(1'b1, 1'b1, 4'b1000, "R5 R8 func out");
    step(1'b1, 1'b1, 4'b0101, "R2 R7 capture");
    step(1'b1, 1'b1, 4'b0000, "R5 R8 func out");

    // R3, R4, R6: shift a walking pattern through unequal chains
    step(1'b1, 1'b0, 4'b0111, "R3 R6 shift");
    for (int n = 0; n < 6; n++) step(1'b1, 1'b0, 4'b0000, "R3 R4 shift");
    step(1'b1, 1'b0, 4'b1001, "R3 R6 shift");
    for (int n = 0; n < 5; n++) step(1'b1, 1'b0, 4'b1000, "R4 R6 tail and core pin");

    // load, capture, unload
    for (int n = 0; n < 4; n++) step(1'b1, 1'b0, 4'b0101, "R3 load");
    step(1'b1, 1'b1, 4'b0011, "R2 capture after load");
    for (int n = 0; n < 5; n++) step(1'b1, 1'b0, 4'b0000, "R3 R4 unload");

    // R9: asynchronous reset in the middle of operation
    step(1'b1, 1'b1, 4'b1111, "R5 before reset");
    step(1'b0, 1'b0, 4'b0000, "R9 async clear");
    step(1'b0, 1'b1, 4'b0000, "R1 R9 cleared core view");
    step(1'b1, 1'b0, 4'b0111, "R9 release edge1");
    step(1'b1, 1'b0, 4'b0111, "R9 release edge2");
    step(1'b1, 1'b0, 4'b0000, "R3 R9 first shift");

    // mixed pseudo-random traffic
    lf = 16'hACE1;
    for (int n = 0; n < 80; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(1'b1, lf[7], lf[3:0], "R2 R3 R4 R5 mixed");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired po=%b expected=finish", po);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule